// File: doc/BRIEF.md
# AES-256 Round Key Expansion Engine

This block turns one 256-bit cipher key into the full AES-256 key schedule: 60 words of 32 bits, grouped four at a time into 15 round keys of 128 bits. A single pulse on `advance` captures the key and starts a pass. The engine then produces one schedule word per cycle. It keeps a sliding window of the last eight words and builds each new word from that window, using a computed byte substitution, a byte rotation and a round constant. Words collect in a shift register, and each full round key is handed to the consumer over a valid/ready stream.

The consumer sets the pace through `rk_ready`. While a round key is offered and `rk_ready` is low, `rk_valid`, `rk_data` and `rk_index` hold steady. Word generation continues until the next round key is complete, then pauses, so no word is ever lost or overwritten. A transfer happens on each rising clock edge where both `rk_valid` and `rk_ready` are high. With `rk_ready` held high, a pass delivers one round key every four cycles. `busy` is high while the controller is generating words.

Top module: `aes256_key_expander`

## Requirements
- R1: Schedule words 0 to 7 are the cipher key words unchanged. Word 0 is `cipher_key[255:224]` and word 7 is `cipher_key[31:0]`. Round key r is words 4r to 4r+3, with word 4r in `rk_data[127:96]`.
- R2: A word whose index is a nonzero multiple of 8 is computed in four steps. Rotate the previous word left by one byte. Substitute each byte through the AES S-box. XOR the round constant into the top byte. XOR the result with the word eight positions back. The constant is 0x01 at word 8 and doubles in GF(2^8) at each later use: 01, 02, 04, 08, 10, 20, 40.
- R3: A word whose index is 4 modulo 8, from index 12 on, is the S-box substitution of each byte of the previous word, with no rotation and no constant, XORed with the word eight positions back.
- R4: Every other word from index 9 on is the previous word XORed with the word eight positions back.
- R5: An accepted `advance` starts a pass that delivers exactly 15 round keys, with `rk_index` running 0, 1, ..., 14 in order.
- R6: With `rk_ready` held high, round key 0 is valid in the cycle after `advance` is accepted, and `busy` stays high for exactly 56 cycles: one word is produced per cycle for words 4 to 59.
- R7: While `rk_valid` is high and `rk_ready` is low, `rk_valid`, `rk_data` and `rk_index` hold their values on the next cycle. Under any pattern of back-pressure, every round key still arrives once, in order, with correct contents.
- R8: `advance` is ignored while `busy` is high or while a round key is still being offered. The pass in progress continues unchanged.
- R9: After word 59 the controller returns to idle (`busy` low), and no further round key appears until a new `advance` is accepted.
- R10: A synchronous active-high `rst` leaves `rk_valid` and `busy` low on the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Start pulse; accepted only when idle with no key on offer |
| cipher_key | input | 256 | Cipher key, sampled when `advance` is accepted |
| rk_valid | output | 1 | A round key is offered on `rk_data` |
| rk_ready | input | 1 | Consumer accepts the offered round key |
| rk_data | output | 128 | Current round key, first word in the top bits |
| rk_index | output | 4 | Round number of the offered key, 0 to 14 |
| busy | output | 1 | Controller is generating words |

## Verification
The embedded assertions watch, on every cycle, the properties that follow from the handshake and the sequencing alone. These are: holding the offer under back-pressure, `busy` rising only on an accepted `advance`, the word counter stepping by one, `rk_index` stepping by one, the round constant staying one-hot, the return to idle after word 59, and the reset state. Whether each word obeys the substitution, rotation and constant rules, and whether the schedule matches published values, can only be shown by the bench scenarios. These compare every delivered word against an independent model. They also check the 56-cycle pass length, stray `advance` pulses during a pass, and the absence of keys after a pass, under both a free-running and a throttled consumer.

// File: rtl/aes256kx_pkg.sv
package aes256kx_pkg;
  localparam int WORD_W    = 32;
  localparam int KEY_WORDS = 8;
  localparam int RK_WORDS  = 4;
  localparam int N_ROUNDS  = 14;
  localparam int N_WORDS   = RK_WORDS * (N_ROUNDS + 1);
  localparam int WIDX_W    = $clog2(N_WORDS);
  localparam int RIDX_W    = $clog2(N_ROUNDS + 1);
  localparam int KEY_W     = WORD_W * KEY_WORDS;
  localparam int RK_W      = WORD_W * RK_WORDS;

  typedef enum logic {KX_IDLE, KX_EXPAND} kx_state_e;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = gf_xtime(x);
    end
    return p;
  endfunction

  // a^254 by an addition chain; maps zero to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] a2, a3, a6, a12, a15, a30, a60, a120, a240, a252;
    a2   = gf_mul(a, a);
    a3   = gf_mul(a2, a);
    a6   = gf_mul(a3, a3);
    a12  = gf_mul(a6, a6);
    a15  = gf_mul(a12, a3);
    a30  = gf_mul(a15, a15);
    a60  = gf_mul(a30, a30);
    a120 = gf_mul(a60, a60);
    a240 = gf_mul(a120, a120);
    a252 = gf_mul(a240, a12);
    return gf_mul(a252, a2);
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/kx_sbox.sv
module kx_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import aes256kx_pkg::*;
  always_comb dout = sub_byte(din);
endmodule

// File: rtl/kx_word_gen.sv
module kx_word_gen
  import aes256kx_pkg::*;
(
  input  logic [WORD_W-1:0] prev_w,
  input  logic [WORD_W-1:0] back_w,
  input  logic [2:0]        phase,
  input  logic [7:0]        rcon,
  output logic [WORD_W-1:0] next_w
);
  localparam int NB = WORD_W / 8;

  logic [WORD_W-1:0] subst;
  logic [WORD_W-1:0] mixed;

  for (genvar b = 0; b < NB; b++) begin : g_sub
    kx_sbox u_sbox (.din(prev_w[8*b +: 8]), .dout(subst[8*b +: 8]));
  end

  // substitution commutes with byte rotation, so rotate after substituting
  always_comb begin
    unique case (phase)
      3'd0:    mixed = {subst[WORD_W-9:0], subst[WORD_W-1 -: 8]} ^ {rcon, {(WORD_W-8){1'b0}}};
      3'd4:    mixed = subst;
      default: mixed = prev_w;
    endcase
    next_w = mixed ^ back_w;
  end
endmodule

// File: rtl/kx_ctrl.sv
module kx_ctrl
  import aes256kx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              rk_ready,
  output logic              load,
  output logic              gen,
  output logic              emit,
  output logic [WIDX_W-1:0] word_idx,
  output logic [7:0]        rcon,
  output logic              out_valid,
  output logic [RIDX_W-1:0] rk_index,
  output logic              busy
);
  kx_state_e          state;
  logic [WIDX_W-1:0]  wcnt;
  logic [1:0]         acnt;
  logic [7:0]         rcon_q;
  logic               vld_q;
  logic [RIDX_W-1:0]  ridx_q;
  logic               last;

  always_comb begin
    load  = (state == KX_IDLE) && !vld_q && advance;
    gen   = (state == KX_EXPAND) && ((acnt != 2'd3) || !vld_q || rk_ready);
    emit  = gen && (acnt == 2'd3);
    last  = gen && (wcnt == WIDX_W'(N_WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= KX_IDLE;
      wcnt   <= '0;
      acnt   <= '0;
      rcon_q <= 8'h01;
      vld_q  <= 1'b0;
      ridx_q <= '0;
    end else if (load) begin
      state  <= KX_EXPAND;
      wcnt   <= WIDX_W'(RK_WORDS);
      acnt   <= '0;
      rcon_q <= 8'h01;
      vld_q  <= 1'b1;
      ridx_q <= '0;
    end else begin
      if (gen) begin
        wcnt <= wcnt + 1'b1;
        acnt <= acnt + 1'b1;
        if (wcnt >= WIDX_W'(KEY_WORDS) && wcnt[2:0] == 3'd0) rcon_q <= gf_xtime(rcon_q);
        if (last) state <= KX_IDLE;
      end
      if (emit) begin
        vld_q  <= 1'b1;
        ridx_q <= ridx_q + 1'b1;
      end else if (rk_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign word_idx  = wcnt;
  assign rcon      = rcon_q;
  assign out_valid = vld_q;
  assign rk_index  = ridx_q;
  assign busy      = (state == KX_EXPAND);

  assert_rcon_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(rcon_q));

  assert_start_on_advance_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(advance) && !$past(vld_q));

  assert_word_step_R6: assert property (@(posedge clk) disable iff (rst)
    (gen && !last) |=> wcnt == WIDX_W'($past(wcnt) + 1'b1));

  assert_index_step_R5: assert property (@(posedge clk) disable iff (rst)
    emit |=> (ridx_q == RIDX_W'($past(ridx_q) + 1'b1)) && (ridx_q <= RIDX_W'(N_ROUNDS)));

  assert_idle_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy);
endmodule

// File: rtl/aes256_key_expander.sv
module aes256_key_expander
  import aes256kx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [KEY_W-1:0]  cipher_key,
  output logic              rk_valid,
  input  logic              rk_ready,
  output logic [RK_W-1:0]   rk_data,
  output logic [RIDX_W-1:0] rk_index,
  output logic              busy
);
  logic              load, gen, emit;
  logic [WIDX_W-1:0] word_idx;
  logic [7:0]        rcon;
  logic [WORD_W-1:0] win [KEY_WORDS];
  logic [RK_W-WORD_W-1:0] acc;
  logic [RK_W-1:0]   out_q;
  logic [WORD_W-1:0] calc_w, new_w;
  logic              from_key;

  kx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .advance(advance), .rk_ready(rk_ready),
    .load(load), .gen(gen), .emit(emit), .word_idx(word_idx), .rcon(rcon),
    .out_valid(rk_valid), .rk_index(rk_index), .busy(busy)
  );

  kx_word_gen u_gen (
    .prev_w(win[KEY_WORDS-1]), .back_w(win[0]),
    .phase(word_idx[2:0]), .rcon(rcon), .next_w(calc_w)
  );

  always_comb begin
    from_key = (word_idx < WIDX_W'(KEY_WORDS));
    new_w    = from_key ? win[word_idx[2:0]] : calc_w;
  end

  for (genvar j = 0; j < KEY_WORDS; j++) begin : g_win
    always_ff @(posedge clk) begin
      if (load)
        win[j] <= cipher_key[KEY_W-1-WORD_W*j -: WORD_W];
      else if (gen && !from_key)
        win[j] <= (j == KEY_WORDS-1) ? calc_w : win[(j+1) % KEY_WORDS];
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_q <= cipher_key[KEY_W-1 -: RK_W];
      acc   <= '0;
    end else if (gen) begin
      acc <= {acc[RK_W-2*WORD_W-1:0], new_w};
      if (emit) out_q <= {acc, new_w};
    end
  end

  assign rk_data = out_q;

  assert_hold_offer_R7: assert property (@(posedge clk) disable iff (rst)
    (rk_valid && !rk_ready) |=> rk_valid && $stable(rk_data) && $stable(rk_index));

  assert_index_range_R5: assert property (@(posedge clk) disable iff (rst)
    rk_valid |-> rk_index <= RIDX_W'(N_ROUNDS));

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;
  always_ff @(posedge clk) begin
    if (rst_seen === 1'b1 && !rst)
      assert_reset_state_R10: assert (!rk_valid && !busy);
  end
endmodule

// File: tb/tb_aes256_key_expander.sv
module tb_aes256_key_expander;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         advance = 1'b0;
  logic [255:0] cipher_key = '0;
  logic         rk_valid;
  logic         rk_ready = 1'b1;
  logic [127:0] rk_data;
  logic [3:0]   rk_index;
  logic         busy;

  aes256_key_expander dut (
    .clk(clk), .rst(rst), .advance(advance), .cipher_key(cipher_key),
    .rk_valid(rk_valid), .rk_ready(rk_ready), .rk_data(rk_data),
    .rk_index(rk_index), .busy(busy)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [131:0] exp_q[$];
  int  got_keys = 0;
  int  busy_cycles = 0;
  bit  throttle = 1'b0;
  bit  fips_run = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  bit  prev_hold = 1'b0;
  logic [127:0] prev_data;
  logic [3:0]   prev_idx;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent reference: brute-force inverse, bitwise affine map
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] a);
    logic [7:0] inv = 8'h00, s;
    for (int c = 1; c < 256; c++) if (ref_mul(a, 8'(c)) == 8'h01) inv = 8'(c);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01);
    return s;
  endfunction

  function automatic logic [31:0] ref_subw(input logic [31:0] w);
    return {ref_sbox(w[31:24]), ref_sbox(w[23:16]), ref_sbox(w[15:8]), ref_sbox(w[7:0])};
  endfunction

  task automatic push_schedule(input logic [255:0] k);
    logic [31:0] w [60];
    logic [7:0]  rc = 8'h01;
    logic [31:0] t;
    for (int i = 0; i < 8; i++) w[i] = k[255-32*i -: 32];
    for (int i = 8; i < 60; i++) begin
      t = w[i-1];
      if (i % 8 == 0) begin
        t = ref_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = (rc == 8'h80) ? 8'h1b : (rc << 1);
      end else if (i % 8 == 4) begin
        t = ref_subw(t);
      end
      w[i] = t ^ w[i-8];
    end
    for (int r = 0; r < 15; r++) exp_q.push_back({4'(r), w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]});
  endtask

  function automatic string word_req(input int pos);
    if (pos < 8) return "R1";
    if (pos % 8 == 0) return "R2";
    if (pos % 8 == 4) return "R3";
    return "R4";
  endfunction

  // monitor: sets ready for this cycle, then scores any transfer at the next edge
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) busy_cycles++;
      if (prev_hold) begin
        checks++;
        if (!(rk_valid && rk_data == prev_data && rk_index == prev_idx)) begin
          errors++;
          $display("FAIL R7 held offer changed: actual=%h/%0d expected=%h/%0d", rk_data, rk_index, prev_data, prev_idx);
        end
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rk_ready = throttle ? (lfsr[0] & lfsr[2]) : 1'b1;
      prev_hold = rk_valid && !rk_ready;
      prev_data = rk_data;
      prev_idx  = rk_index;
      if (rk_valid && rk_ready) begin
        got_keys++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected round key", rk_data, '0);
        end else begin
          logic [131:0] e;
          e = exp_q.pop_front();
          check(rk_index == e[131:128], "R5 round index", 128'(rk_index), 128'(e[131:128]));
          for (int k = 0; k < 4; k++)
            check(rk_data[127-32*k -: 32] == e[127-32*k -: 32], word_req(4*int'(e[131:128]) + k),
                  128'(rk_data[127-32*k -: 32]), 128'(e[127-32*k -: 32]));
          if (fips_run && rk_index == 4'd2)
            check(rk_data == 128'h9ba354118e6925afa51a8b5f2067fcde, "R2 published round key 2", rk_data, 128'h9ba354118e6925afa51a8b5f2067fcde);
          if (fips_run && rk_index == 4'd14)
            check(rk_data == 128'hfe4890d1e6188d0b046df344706c631e, "R2 published round key 14", rk_data, 128'hfe4890d1e6188d0b046df344706c631e);
        end
      end
    end
  end

  task automatic run_pass(input logic [255:0] k, input bit thr, input bit fips);
    int guard = 0;
    throttle = thr;
    fips_run = fips;
    got_keys = 0;
    busy_cycles = 0;
    push_schedule(k);
    @(negedge clk);
    cipher_key = k;
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check(rk_valid == 1'b1 && busy == 1'b1, "R6 key 0 offered after advance", 128'({rk_valid, busy}), 128'h3);
    // stray advance pulses with a different key while the pass runs
    while ((busy || rk_valid) && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (busy && guard % 7 == 3) begin
        cipher_key = ~k;
        advance = 1'b1;
      end else begin
        advance = 1'b0;
      end
    end
    advance = 1'b0;
    repeat (30) @(negedge clk);
    check(got_keys == 15, "R5 fifteen round keys per pass", 128'(got_keys), 128'd15);
    check(exp_q.size() == 0, "R8 no key lost or replaced", 128'(exp_q.size()), 128'd0);
    check(busy == 1'b0 && rk_valid == 1'b0, "R9 idle after pass", 128'({busy, rk_valid}), 128'h0);
    if (!thr) check(busy_cycles == 56, "R6 pass length", 128'(busy_cycles), 128'd56);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rk_valid == 1'b0 && busy == 1'b0, "R10 reset state", 128'({rk_valid, busy}), 128'h0);
    rst = 1'b0;
    @(negedge clk);
    check(rk_valid == 1'b0 && busy == 1'b0, "R10 idle after reset", 128'({rk_valid, busy}), 128'h0);
    run_pass(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, 1'b0, 1'b1);
    run_pass(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 1'b1, 1'b0);
    run_pass(256'hffffffff00000000a5a5a5a55a5a5a5a0123456789abcdeffedcba9876543210, 1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule